// File: doc/BRIEF.md
# Slave-Mode Serial Audio Port

This block is the receive and transmit engine of a stereo serial audio link in which a remote device owns the clocks. An external bit clock and a word-select line arrive as inputs that are sampled with the system clock. Word select low marks the left slot and high marks the right slot. The first data bit of each slot follows one bit clock after the word-select edge, most significant bit first. Received words are gathered into one holding register that both channels share. Words to send come from a second shared holding register. Software or a DMA engine moves whole words through a four-address register port.

Enabling the port does not start it at once. It waits for a word-select falling edge so that the first word delivered is always a left word. Disabling it is also not immediate. The port finishes the stereo frame that is in progress, still timed by the remote word-select edges, and only then reports idle. If the remote clocks stop first, the port freezes where it is. Enabling it again in that state continues the interrupted word rather than starting clean. A word that completes while the receive holding register is still unread is dropped and raises a sticky overflow flag. A transmit slot that begins with no word waiting sends zeros and raises a sticky underflow flag.

Register map (`addr`): 0 = control (bit 0 enable, bit 1 DMA-request enable). 1 = status (bit 0 idle, bit 1 overflow, bit 2 underflow, bit 3 receive word waiting, bit 4 channel of that word with 1 = right, bit 5 transmit word waiting). 2 = receive data; reading it empties the holding register. 3 = transmit data; writing it fills the holding register.

Top module: `audio_slave_port`

## Requirements
- R1: A received word is the WORD_W bits sampled on bit-clock rising edges, MSB first. It starts one bit clock after a word-select change and completes at the next change. It lands in the holding register tagged with the slot's channel (status bit 4: 0 for left while word select was low, 1 for right).
- R2: At each word-select change during a transfer, the transmit shifter loads the waiting transmit word, and its MSB is on `sdo` for the following bit period. If no word waits, the slot sends all zeros and status bit 2 (underflow) sets.
- R3: A word that completes while the receive holding register is full is discarded, the held word is kept, and status bit 1 (overflow) sets.
- R4: The overflow and underflow flags are sticky. Each clears only when software writes 0 to its bit at address 1; writing 1 leaves it set.
- R5: `rx_dreq` is high exactly while enable, DMA-request enable and receive-word-waiting are all set, and a read of address 2 drops it. `tx_dreq` is high while enable and DMA-request enable are set and no transmit word waits.
- R6: From idle, a transfer starts at a word-select falling edge. If the port is enabled during a left slot, that slot is skipped and the transfer starts at the following falling edge. No word is delivered at the start edge.
- R7: When enable is cleared mid-transfer, the port keeps running to the end of the current stereo frame and delivers the right word. Idle (status bit 0) stays 0 until then, sets at the word-select falling edge that ends the frame, and stays 1 while enable is 0.
- R8: If the bit clock stops before idle sets, the port stays non-idle. Enabling it again continues the interrupted word, which is delivered complete at the next word-select change.
- R9: Leaving idle empties the receive holding register, so after the recovery sequence (clear enables, wait for idle, clear overflow, enable) the first word delivered is a left word.
- R10: `irq` is high whenever the overflow or underflow flag is set.
- R11: After reset the port is idle, both flags and both holding registers are empty, `sdo` is 0 and both request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every input |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | External serial bit clock |
| ws | input | 1 | External word select, low = left slot |
| sdi | input | 1 | Serial receive data |
| sdo | output | 1 | Serial transmit data |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | WORD_W | Register write data |
| rdata | output | WORD_W | Register read data (combinational on addr) |
| rx_dreq | output | 1 | Receive DMA request |
| tx_dreq | output | 1 | Transmit DMA request |
| irq | output | 1 | Error interrupt (overflow or underflow) |

## Verification
The bench runs a continuous stereo stream with a sweep of per-slot words: all ones, all zeros, and an arithmetic sequence. This separates bit-order and one-bit-delay mistakes from channel-tag mistakes, and it checks every transmitted slot against the word written for it. The stream is then bent into the cases that separate the control behaviours. Leaving reads out shows whether the old or the new word survives an overflow. Disabling mid-left shows whether the right word of the frame is still delivered before idle. Enabling mid-left shows that the first falling edge is skipped. Stopping the bit clock mid-word and then resuming shows a continued word rather than a clean restart.

// File: rtl/asp_pkg.sv
package asp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SYNC = 2'd1,
        ST_RUN  = 2'd2
    } asp_state_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_RXD  = 2'd2;
    localparam logic [1:0] ADDR_TXD  = 2'd3;

    localparam int CTRL_EN    = 0;
    localparam int CTRL_DMA   = 1;
    localparam int STAT_IDLE  = 0;
    localparam int STAT_OVF   = 1;
    localparam int STAT_UNF   = 2;
    localparam int STAT_RXF   = 3;
    localparam int STAT_CHAN  = 4;
    localparam int STAT_TXF   = 5;
    localparam int STAT_BITS  = 6;
endpackage

// File: rtl/asp_edge.sv
module asp_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic ws,
    output logic tick,
    output logic ws_rise,
    output logic ws_fall,
    output logic ws_prev
);
    typedef struct packed {
        logic sck;
        logic ws;
    } edge_st_t;

    edge_st_t st_d, st_q;

    assign tick    = sck & ~st_q.sck;
    assign ws_rise = tick & ~st_q.ws & ws;
    assign ws_fall = tick & st_q.ws & ~ws;
    assign ws_prev = st_q.ws;

    always_comb begin
        st_d     = st_q;
        st_d.sck = sck;
        if (tick) begin
            st_d.ws = ws;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/asp_rx.sv
module asp_rx #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              shift_en,
    input  logic              sdi,
    input  logic              deliver,
    input  logic              chan_in,
    input  logic              rd_clr,
    input  logic              restart,
    input  logic              ovf_clr,
    output logic [WORD_W-1:0] hold,
    output logic              full,
    output logic              chan,
    output logic              ovf
);
    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [WORD_W-1:0] hold;
        logic              full;
        logic              chan;
        logic              ovf;
    } rx_st_t;

    rx_st_t st_d, st_q;
    logic [WORD_W-1:0] word;

    assign word = {st_q.sh[WORD_W-2:0], sdi};

    always_comb begin
        st_d = st_q;
        if (tick && shift_en) begin
            st_d.sh = word;
        end
        if (rd_clr) begin
            st_d.full = 1'b0;
        end
        if (ovf_clr) begin
            st_d.ovf = 1'b0;
        end
        if (deliver) begin
            if (st_q.full && !rd_clr) begin
                st_d.ovf = 1'b1;
            end else begin
                st_d.hold = word;
                st_d.full = 1'b1;
                st_d.chan = chan_in;
            end
        end
        if (restart) begin
            st_d.full = 1'b0;
            st_d.sh   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold = st_q.hold;
    assign full = st_q.full;
    assign chan = st_q.chan;
    assign ovf  = st_q.ovf;

    assert_overflow_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.full && deliver && !rd_clr) |=> $stable(st_q.hold));

    assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovf && !ovf_clr) |=> st_q.ovf);
endmodule

// File: rtl/asp_tx.sv
module asp_tx #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              shift_en,
    input  logic              load,
    input  logic              flush,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              unf_clr,
    output logic              sdo,
    output logic              full,
    output logic              unf
);
    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [WORD_W-1:0] hold;
        logic              full;
        logic              unf;
    } tx_st_t;

    tx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (unf_clr) begin
            st_d.unf = 1'b0;
        end
        if (load) begin
            if (st_q.full) begin
                st_d.sh   = st_q.hold;
                st_d.full = 1'b0;
            end else begin
                st_d.sh  = '0;
                st_d.unf = 1'b1;
            end
        end else if (tick && shift_en) begin
            st_d.sh = {st_q.sh[WORD_W-2:0], 1'b0};
        end
        if (flush) begin
            st_d.sh = '0;
        end
        if (wr) begin
            st_d.hold = wdata;
            st_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdo  = st_q.sh[WORD_W-1];
    assign full = st_q.full;
    assign unf  = st_q.unf;

    assert_empty_slot_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !st_q.full && !unf_clr) |=> (!sdo && st_q.unf));
endmodule

// File: rtl/audio_slave_port.sv
module audio_slave_port
    import asp_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              ws,
    input  logic              sdi,
    output logic              sdo,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              rx_dreq,
    output logic              tx_dreq,
    output logic              irq
);
    localparam int PAD_W = WORD_W - STAT_BITS;

    typedef struct packed {
        asp_state_e state;
        logic       en;
        logic       dma;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    logic tick, ws_rise, ws_fall, ws_prev;
    logic deliver, tx_load, tx_flush, rx_restart, running;
    logic rd_clr, tx_wr, ovf_clr, unf_clr;
    logic [WORD_W-1:0] rx_hold;
    logic rx_full, rx_chan, ovf, tx_full, unf;

    asp_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck     (sck),
        .ws      (ws),
        .tick    (tick),
        .ws_rise (ws_rise),
        .ws_fall (ws_fall),
        .ws_prev (ws_prev)
    );

    assign running = (st_q.state == ST_RUN);
    assign rd_clr  = rd_en && (addr == ADDR_RXD);
    assign tx_wr   = wr_en && (addr == ADDR_TXD);
    assign ovf_clr = wr_en && (addr == ADDR_STAT) && !wdata[STAT_OVF];
    assign unf_clr = wr_en && (addr == ADDR_STAT) && !wdata[STAT_UNF];

    always_comb begin
        st_d       = st_q;
        deliver    = 1'b0;
        tx_load    = 1'b0;
        tx_flush   = 1'b0;
        rx_restart = 1'b0;
        if (wr_en && (addr == ADDR_CTRL)) begin
            st_d.en  = wdata[CTRL_EN];
            st_d.dma = wdata[CTRL_DMA];
        end
        case (st_q.state)
            ST_IDLE: begin
                if (st_q.en) begin
                    st_d.state = ST_SYNC;
                    rx_restart = 1'b1;
                end
            end
            ST_SYNC: begin
                if (!st_q.en) begin
                    st_d.state = ST_IDLE;
                end else if (ws_fall) begin
                    st_d.state = ST_RUN;
                    tx_load    = 1'b1;
                end
            end
            ST_RUN: begin
                if (ws_rise || ws_fall) begin
                    deliver = 1'b1;
                    if (ws_fall && !st_q.en) begin
                        st_d.state = ST_IDLE;
                        tx_flush   = 1'b1;
                    end else begin
                        tx_load = 1'b1;
                    end
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: ST_IDLE, en: 1'b0, dma: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    asp_rx #(.WORD_W(WORD_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .shift_en (running),
        .sdi      (sdi),
        .deliver  (deliver),
        .chan_in  (ws_prev),
        .rd_clr   (rd_clr),
        .restart  (rx_restart),
        .ovf_clr  (ovf_clr),
        .hold     (rx_hold),
        .full     (rx_full),
        .chan     (rx_chan),
        .ovf      (ovf)
    );

    asp_tx #(.WORD_W(WORD_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .shift_en (running),
        .load     (tx_load),
        .flush    (tx_flush),
        .wr       (tx_wr),
        .wdata    (wdata),
        .unf_clr  (unf_clr),
        .sdo      (sdo),
        .full     (tx_full),
        .unf      (unf)
    );

    always_comb begin
        case (addr)
            ADDR_CTRL: rdata = {{(WORD_W-2){1'b0}}, st_q.dma, st_q.en};
            ADDR_STAT: rdata = {{PAD_W{1'b0}}, tx_full, rx_chan, rx_full, unf, ovf,
                                (st_q.state == ST_IDLE)};
            ADDR_RXD:  rdata = rx_hold;
            default:   rdata = '0;
        endcase
    end

    assign rx_dreq = st_q.en & st_q.dma & rx_full;
    assign tx_dreq = st_q.en & st_q.dma & ~tx_full;
    assign irq     = ovf | unf;

    assert_read_drops_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !deliver) |=> !rx_dreq);

    assert_idle_holds_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.state == ST_IDLE) && !st_q.en && !(wr_en && (addr == ADDR_CTRL)))
            |=> (st_q.state == ST_IDLE));

    assert_frozen_without_clock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !tick) |=> running);

    assert_flag_drives_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> irq);
endmodule

// File: tb/audio_slave_port_bench.sv
module audio_slave_port_bench;
    localparam int W = 8;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, ws = 1'b0, sdi = 1'b0;
    logic sdo;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic rx_dreq, tx_dreq, irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic prev_bit = 1'b0;
    logic [W-1:0] acc = '0;
    logic [W-1:0] last_tx = '0;
    logic [W-1:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    audio_slave_port #(.WORD_W(W)) u_audio_slave_port (
        .clk(clk), .rst_n(rst_n), .sck(sck), .ws(ws), .sdi(sdi), .sdo(sdo),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .rx_dreq(rx_dreq), .tx_dreq(tx_dreq), .irq(irq)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic [W-1:0] dword(input int k);
        int v;
        if (k == 0) v = 32'hFF;
        else if (k == 1) v = 0;
        else v = k * 59 + 17;
        return v[W-1:0];
    endfunction

    function automatic logic [W-1:0] tword(input int k);
        return ~dword(k) ^ 8'h3C;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [W-1:0] d);
        @(negedge clk);
        addr = a; rd_en = (a == 2'd2);
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic send_bits(input logic w, input logic [W-1:0] word, input int b0, input int b1);
        for (int b = b0; b <= b1; b++) begin
            @(negedge clk);
            sck = 1'b0; ws = w; sdi = prev_bit; prev_bit = word[W-1-b];
            @(negedge clk);
            if (b == 0) begin
                last_tx = {acc[W-2:0], sdo};
                acc = '0;
            end else begin
                acc = {acc[W-2:0], sdo};
            end
            sck = 1'b1;
            @(negedge clk);
            @(negedge clk);
        end
    endtask

    task automatic send_slot(input logic w, input logic [W-1:0] word);
        send_bits(w, word, 0, W-1);
    endtask

    task automatic expect_word(input string req, input logic ch, input logic [W-1:0] d);
        logic [W-1:0] s;
        reg_rd(2'd1, s);
        chk({req, " word waiting"}, s[3], 1'b1);
        chk({req, " channel tag"}, s[4], ch);
        reg_rd(2'd2, s);
        chk({req, " word value"}, s, d);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        reg_rd(2'd1, rv);
        chk("R11 status", rv, 8'h01);
        chk("R11 sdo", sdo, 1'b0);
        chk("R11 rx_dreq", rx_dreq, 1'b0);
        chk("R11 tx_dreq", tx_dreq, 1'b0);
        chk("R11 irq", irq, 1'b0);

        // R1 R2 R5 R6 stream sweep, enabled while word select high
        reg_wr(2'd3, tword(0));
        reg_wr(2'd0, 8'h03);
        chk("R5 tx_dreq while word waits", tx_dreq, 1'b0);
        send_slot(1'b1, 8'h5A);
        for (int k = 0; k < 12; k++) begin
            send_slot(k[0], dword(k));
            if (k >= 1) begin
                chk("R5 rx_dreq raised", rx_dreq, 1'b1);
                expect_word("R1", ~k[0], dword(k-1));
                chk("R5 rx_dreq dropped by read", rx_dreq, 1'b0);
                chk("R2 transmitted word", last_tx, tword(k-1));
            end
            chk("R5 tx_dreq after load", tx_dreq, 1'b1);
            reg_wr(2'd3, tword(k+1));
        end

        // R3 overflow, R2 underflow, R4 stickiness, R10
        send_slot(1'b0, dword(12));
        send_slot(1'b1, dword(13));
        reg_rd(2'd1, rv);
        chk("R3 overflow flag", rv[1], 1'b1);
        chk("R10 irq on overflow", irq, 1'b1);
        chk("R2 last loaded word", last_tx, tword(12));
        expect_word("R3 old word kept", 1'b1, dword(11));
        send_slot(1'b0, dword(14));
        chk("R2 empty slot sends zeros", last_tx, 8'h00);
        reg_wr(2'd1, 8'h06);
        reg_rd(2'd1, rv);
        chk("R4 overflow kept on write 1", rv[1], 1'b1);
        chk("R4 underflow kept on write 1", rv[2], 1'b1);

        // R7 shutdown finishing frame, R9 recovery
        reg_wr(2'd0, 8'h00);
        send_slot(1'b1, dword(15));
        reg_rd(2'd1, rv);
        chk("R7 not idle before frame end", rv[0], 1'b0);
        send_slot(1'b0, dword(16));
        reg_rd(2'd1, rv);
        chk("R7 idle at frame end", rv[0], 1'b1);
        reg_wr(2'd1, 8'h00);
        reg_rd(2'd1, rv);
        chk("R4 overflow cleared by 0", rv[1], 1'b0);
        chk("R4 underflow cleared by 0", rv[2], 1'b0);
        chk("R10 irq cleared", irq, 1'b0);
        reg_wr(2'd0, 8'h03);
        reg_rd(2'd1, rv);
        chk("R9 holding emptied on enable", rv[3], 1'b0);
        reg_wr(2'd3, tword(17));
        send_slot(1'b1, dword(17));
        send_slot(1'b0, dword(18));
        send_slot(1'b1, dword(19));
        expect_word("R9 first word left", 1'b0, dword(18));

        // R7 disable mid-left
        send_bits(1'b0, dword(20), 0, 3);
        expect_word("R1 right", 1'b1, dword(19));
        reg_wr(2'd0, 8'h02);
        reg_rd(2'd1, rv);
        chk("R7 busy after disable", rv[0], 1'b0);
        send_bits(1'b0, dword(20), 4, W-1);
        send_slot(1'b1, dword(21));
        reg_rd(2'd1, rv);
        chk("R7 busy in right slot", rv[0], 1'b0);
        chk("R5 no request when disabled", rx_dreq, 1'b0);
        expect_word("R7 left finished", 1'b0, dword(20));
        send_bits(1'b0, dword(22), 0, 0);
        reg_rd(2'd1, rv);
        chk("R7 idle after right", rv[0], 1'b1);
        expect_word("R7 right delivered", 1'b1, dword(21));

        // R6 enable mid-left: second falling edge
        reg_wr(2'd0, 8'h03);
        send_bits(1'b0, dword(22), 1, W-1);
        send_slot(1'b1, dword(23));
        reg_rd(2'd1, rv);
        chk("R6 skipped slot not delivered", rv[3], 1'b0);
        send_slot(1'b0, dword(24));
        reg_rd(2'd1, rv);
        chk("R6 nothing at start edge", rv[3], 1'b0);
        send_slot(1'b1, dword(25));
        expect_word("R6 first word", 1'b0, dword(24));

        // R8 suspend and resume
        send_bits(1'b0, dword(26), 0, 3);
        expect_word("R8 before suspend", 1'b1, dword(25));
        reg_wr(2'd0, 8'h02);
        repeat (200) @(negedge clk);
        reg_rd(2'd1, rv);
        chk("R8 stays busy when frozen", rv[0], 1'b0);
        reg_wr(2'd0, 8'h03);
        send_bits(1'b0, dword(26), 4, W-1);
        send_bits(1'b1, dword(27), 0, 0);
        expect_word("R8 resumed word", 1'b0, dword(26));

        // R5 DMA-request enable off
        reg_wr(2'd0, 8'h01);
        send_bits(1'b1, dword(27), 1, W-1);
        send_bits(1'b0, dword(28), 0, 0);
        chk("R5 rx_dreq masked", rx_dreq, 1'b0);
        chk("R5 tx_dreq masked", tx_dreq, 1'b0);
        expect_word("R5 word still held", 1'b1, dword(27));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule